// File: doc/BRIEF.md
# Glitch-Free Clock Output Gater

This block sits between a set of free-running source clocks and their output drivers and decides, for each output, whether the clock passes through, is parked, or is switched off. There are two kinds of output. Single-ended outputs park low. Differential pairs park with the true line high. Two requests can stop an output. The first is a power-down request, which is taken only after it has been confirmed on the reference clock. The second is a software run/stop bit, which acts only on the outputs marked stoppable.

Each output has its own small gate state machine. The gate closes only at the edge that carries the source into the park level, and it reopens only while the source sits at that level. The output therefore never shows a partial high or low phase. The source clocks are sampled by the fast system clock `clk`. They must hold each level for at least two `clk` cycles. After power-down is released, a differential pair that was floating is driven to its parked-high state for a fixed number of `clk` cycles before it runs again.

Top module: `clk_out_gater`

## Requirements
- R1: While `rst` is high, every single-ended level is 0 and its output enable equals its enable bit. Every differential pair drives true=0 and complement=1 with both enables at 1.
- R2: With `sw_run`=1 and no power-down, an enabled output follows its source. A single-ended output copies the source level. A differential pair drives the source on the true line and its inverse on the complement line.
- R3: When `sw_run` is 0, a single-ended output whose stoppable bit is 1 stops low, still driven (enable 1), on the next falling edge of its source. A single-ended output whose stoppable bit is 0 keeps running.
- R4: No runt phases: every high phase of a single-ended output and every low phase of a differential true line lasts at least one full source half period.
- R5: When `sw_run` is 0, a stoppable differential pair parks on the next rising edge of its true source. With `df_stop_hiz`=0 the pair drives true=1 with true enable 1 and complement enable 0. With `df_stop_hiz`=1 both enables are 0. A pair that is not stoppable keeps running.
- R6: Setting `sw_run` back to 1 resumes the stopped outputs. The gate reopens only while the source is at the park level.
- R7: Power-down starts only after `pd_req` has been sampled high on two consecutive rising edges of the complement line of differential source `CPU_IDX`. Seen high on only one such edge, it has no effect.
- R8: During power-down, all single-ended outputs park low and stay driven. Each differential pair parks high, and its power-down drive-mode bit picks driven (0: true=1, true enable 1, complement enable 0) or floating (1: both enables 0).
- R9: When `pd_req` falls during power-down, every parked differential pair drives true high at once (true enable 1, complement enable 0). This lasts exactly `WAKE_CYC` cycles. After that the outputs resume.
- R10: An output whose enable bit is 0 has every output enable at 0 and every level at 0, whatever the stop and power-down state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| se_src | input | N_SE | Single-ended source clock levels |
| df_src | input | N_DF | Differential source clock levels (true phase) |
| pd_req | input | 1 | Synchronized power-down request |
| sw_run | input | 1 | Software run (1) / stop (0) |
| se_en | input | N_SE | Single-ended output enables |
| se_stoppable | input | N_SE | Single-ended stoppable bits |
| df_en | input | N_DF | Differential output enables |
| df_stoppable | input | N_DF | Differential stoppable bits |
| df_pd_hiz | input | N_DF | Power-down drive mode per pair (1 = float) |
| df_stop_hiz | input | 1 | Software-stop drive mode for pairs (1 = float) |
| se_lvl | output | N_SE | Single-ended output levels |
| se_oe | output | N_SE | Single-ended output enables |
| df_t | output | N_DF | Differential true levels |
| df_c | output | N_DF | Differential complement levels |
| df_t_oe | output | N_DF | True-line output enables |
| df_c_oe | output | N_DF | Complement-line output enables |

## Verification
The hardest situation to reach from the ports is a power-down request that lands on exactly one rising edge of the reference complement clock. The bench generates every source clock itself with a known phase. It waits for the reference source's falling edge, raises `pd_req` right after it and drops it before the next one. Only one qualifying edge sees the request, and the check confirms the outputs keep running. The wake window also needs a pair left floating by power-down. To get one, the bench programs one pair for floating, enters power-down and then releases it, and checks that the true line is driven high from the next cycle and until `WAKE_CYC` has elapsed.

// File: rtl/clk_gate_pkg.sv
package clk_gate_pkg;

    typedef enum logic [1:0] {
        G_RUN      = 2'd0,
        G_STOPPING = 2'd1,
        G_PARKED   = 2'd2
    } gate_st_e;

    typedef enum logic [1:0] {
        PD_IDLE  = 2'd0,
        PD_SEEN1 = 2'd1,
        PD_DOWN  = 2'd2,
        PD_WAKE  = 2'd3
    } pd_st_e;

    typedef struct packed {
        logic t;
        logic c;
        logic t_oe;
        logic c_oe;
    } df_pin_t;

    // Edge that carries the source into its park level.
    function automatic logic park_edge(input logic park_high, input logic cur, input logic prev);
        return park_high ? (cur & ~prev) : (~cur & prev);
    endfunction

    // Pin mapping for one differential pair.
    function automatic df_pin_t df_map(input logic en, input logic parked,
                                       input logic lvl, input logic float_sel);
        df_pin_t p;
        if (!en) begin
            p = '0;
        end else if (!parked) begin
            p = '{t: lvl, c: ~lvl, t_oe: 1'b1, c_oe: 1'b1};
        end else begin
            p = '{t: 1'b1, c: 1'b0, t_oe: ~float_sel, c_oe: 1'b0};
        end
        return p;
    endfunction

endpackage

// File: rtl/src_sampler.sv
module src_sampler #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] src,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                cur[i]  <= 1'b0;
                prev[i] <= 1'b0;
            end else begin
                cur[i]  <= src[i];
                prev[i] <= cur[i];
            end
        end
    end
endmodule

// File: rtl/pd_qualifier.sv
module pd_qualifier
    import clk_gate_pkg::*;
#(
    parameter int WAKE_CYC = 37500
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   ref_edge,
    input  logic   pd_req,
    output pd_st_e st,
    output logic   pd_hold,
    output logic   pd_wake
);
    localparam int CW = $clog2(WAKE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(WAKE_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= PD_IDLE;
            cnt <= '0;
        end else begin
            unique case (st)
                PD_IDLE:  if (ref_edge && pd_req) st <= PD_SEEN1;
                PD_SEEN1: if (ref_edge) st <= pd_req ? PD_DOWN : PD_IDLE;
                PD_DOWN: begin
                    cnt <= '0;
                    if (!pd_req) st <= PD_WAKE;
                end
                PD_WAKE: begin
                    if (cnt == LAST) begin
                        st  <= PD_IDLE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= PD_IDLE;
            endcase
        end
    end

    assign pd_hold = (st == PD_DOWN) || (st == PD_WAKE);
    assign pd_wake = (st == PD_WAKE);
endmodule

// File: rtl/out_gate.sv
module out_gate
    import clk_gate_pkg::*;
#(
    parameter bit PARK_HIGH = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic cur,
    input  logic prev,
    input  logic want,
    output logic parked
);
    gate_st_e st;
    logic     at_park;
    logic     into_park;

    assign at_park   = PARK_HIGH ? cur : ~cur;
    assign into_park = park_edge(PARK_HIGH, cur, prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= G_RUN;
        end else begin
            unique case (st)
                G_RUN:      if (want) st <= into_park ? G_PARKED : G_STOPPING;
                G_STOPPING: if (!want) st <= G_RUN;
                            else if (into_park) st <= G_PARKED;
                G_PARKED:   if (!want && at_park) st <= G_RUN;
                default:    st <= G_RUN;
            endcase
        end
    end

    assign parked = (st == G_PARKED);
endmodule

// File: rtl/clk_out_gater.sv
module clk_out_gater
    import clk_gate_pkg::*;
#(
    parameter int N_SE     = 3,
    parameter int N_DF     = 2,
    parameter int CPU_IDX  = 0,
    parameter int WAKE_CYC = 37500
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_SE-1:0] se_src,
    input  logic [N_DF-1:0] df_src,
    input  logic            pd_req,
    input  logic            sw_run,
    input  logic [N_SE-1:0] se_en,
    input  logic [N_SE-1:0] se_stoppable,
    input  logic [N_DF-1:0] df_en,
    input  logic [N_DF-1:0] df_stoppable,
    input  logic [N_DF-1:0] df_pd_hiz,
    input  logic            df_stop_hiz,
    output logic [N_SE-1:0] se_lvl,
    output logic [N_SE-1:0] se_oe,
    output logic [N_DF-1:0] df_t,
    output logic [N_DF-1:0] df_c,
    output logic [N_DF-1:0] df_t_oe,
    output logic [N_DF-1:0] df_c_oe
);
    logic [N_SE-1:0] se_q, se_d, se_parked;
    logic [N_DF-1:0] df_q, df_d, df_parked;
    pd_st_e          pd_st;
    logic            pd_hold, pd_wake, ref_edge;

    src_sampler #(.W(N_SE)) u_se_smp (
        .clk(clk), .rst(rst), .src(se_src), .cur(se_q), .prev(se_d));
    src_sampler #(.W(N_DF)) u_df_smp (
        .clk(clk), .rst(rst), .src(df_src), .cur(df_q), .prev(df_d));

    // Rising edge of the complement line = falling edge of the true source.
    assign ref_edge = park_edge(1'b0, df_q[CPU_IDX], df_d[CPU_IDX]);

    pd_qualifier #(.WAKE_CYC(WAKE_CYC)) u_pdq (
        .clk(clk), .rst(rst), .ref_edge(ref_edge), .pd_req(pd_req),
        .st(pd_st), .pd_hold(pd_hold), .pd_wake(pd_wake));

    for (genvar i = 0; i < N_SE; i++) begin : g_se
        logic want;
        assign want = pd_hold | (~sw_run & se_stoppable[i]);
        out_gate #(.PARK_HIGH(1'b0)) u_gate (
            .clk(clk), .rst(rst), .cur(se_q[i]), .prev(se_d[i]),
            .want(want), .parked(se_parked[i]));
        assign se_lvl[i] = se_en[i] & ~se_parked[i] & se_q[i];
        assign se_oe[i]  = se_en[i];
    end

    for (genvar i = 0; i < N_DF; i++) begin : g_df
        logic    want, float_sel;
        df_pin_t pin;
        assign want      = pd_hold | (~sw_run & df_stoppable[i]);
        assign float_sel = pd_wake ? 1'b0 : (pd_hold ? df_pd_hiz[i] : df_stop_hiz);
        out_gate #(.PARK_HIGH(1'b1)) u_gate (
            .clk(clk), .rst(rst), .cur(df_q[i]), .prev(df_d[i]),
            .want(want), .parked(df_parked[i]));
        assign pin        = df_map(df_en[i], df_parked[i], df_q[i], float_sel);
        assign df_t[i]    = pin.t;
        assign df_c[i]    = pin.c;
        assign df_t_oe[i] = pin.t_oe;
        assign df_c_oe[i] = pin.c_oe;
    end
endmodule

// File: rtl/clk_out_gater_chk.sv
module clk_out_gater_chk
    import clk_gate_pkg::*;
#(
    parameter int N_SE     = 3,
    parameter int N_DF     = 2,
    parameter int WAKE_CYC = 37500
) (
    input logic            clk,
    input logic            rst,
    input logic            pd_req,
    input logic [N_SE-1:0] se_en,
    input logic [N_SE-1:0] se_lvl,
    input logic [N_SE-1:0] se_q,
    input logic [N_SE-1:0] se_parked,
    input logic [N_DF-1:0] df_q,
    input logic [N_DF-1:0] df_parked,
    input pd_st_e          pd_st
);
    localparam int CW = $clog2(WAKE_CYC + 2);
    logic [CW-1:0] wake_cnt;

    always_ff @(posedge clk) begin
        if (rst)                  wake_cnt <= '0;
        else if (pd_st == PD_WAKE) wake_cnt <= wake_cnt + 1'b1;
        else                      wake_cnt <= '0;
    end

    for (genvar i = 0; i < N_SE; i++) begin : g_se
        a_r3_se_parks_after_fall: assert property (@(posedge clk) disable iff (rst)
            $rose(se_parked[i]) |-> !$past(se_q[i]));
        a_r6_se_reopens_low: assert property (@(posedge clk) disable iff (rst)
            $fell(se_parked[i]) |-> !$past(se_q[i]));
        a_r4_se_parked_steady: assert property (@(posedge clk) disable iff (rst)
            (se_parked[i] && $past(se_parked[i]) && $stable(se_en[i])) |-> $stable(se_lvl[i]));
    end

    for (genvar i = 0; i < N_DF; i++) begin : g_df
        a_r5_df_parks_high: assert property (@(posedge clk) disable iff (rst)
            $rose(df_parked[i]) |-> $past(df_q[i]));
        a_r6_df_reopens_high: assert property (@(posedge clk) disable iff (rst)
            $fell(df_parked[i]) |-> $past(df_q[i]));
    end

    a_r7_pd_two_edges: assert property (@(posedge clk) disable iff (rst)
        (pd_st == PD_DOWN && $past(pd_st) != PD_DOWN) |-> ($past(pd_st) == PD_SEEN1 && $past(pd_req)));

    a_r9_wake_bounded: assert property (@(posedge clk) disable iff (rst)
        wake_cnt <= CW'(WAKE_CYC));
endmodule

bind clk_out_gater clk_out_gater_chk #(
    .N_SE(N_SE), .N_DF(N_DF), .WAKE_CYC(WAKE_CYC)
) u_chk (
    .clk(clk), .rst(rst), .pd_req(pd_req), .se_en(se_en), .se_lvl(se_lvl),
    .se_q(se_q), .se_parked(se_parked), .df_q(df_q), .df_parked(df_parked),
    .pd_st(pd_st)
);

// File: tb/tb_clk_out_gater.sv
module tb_clk_out_gater;
    localparam int N_SE = 3;
    localparam int N_DF = 2;
    localparam int WAKE = 20;
    localparam int H_SE = 4;
    localparam int H_DF = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N_SE-1:0] se_src, se_en, se_stoppable, se_lvl, se_oe;
    logic [N_DF-1:0] df_src, df_en, df_stoppable, df_pd_hiz, df_t, df_c, df_t_oe, df_c_oe;
    logic pd_req, sw_run, df_stop_hiz;
    logic se_clk, df_clk;
    int   se_c, df_c_cnt;
    int   total = 0, bad = 0;
    logic [N_SE-1:0] se_hi, se_lo;
    logic [N_DF-1:0] dt_hi, dt_lo;
    int   runts = 0, run_se = 0, run_df = 0, pulses = 0;
    logic mon_on = 1'b0;
    logic prev_se = 1'b0, prev_df = 1'b1;

    always #4 clk = ~clk;

    assign se_src = {N_SE{se_clk}};
    assign df_src = {N_DF{df_clk}};

    clk_out_gater #(.N_SE(N_SE), .N_DF(N_DF), .CPU_IDX(0), .WAKE_CYC(WAKE)) dut (
        .clk(clk), .rst(rst), .se_src(se_src), .df_src(df_src), .pd_req(pd_req),
        .sw_run(sw_run), .se_en(se_en), .se_stoppable(se_stoppable), .df_en(df_en),
        .df_stoppable(df_stoppable), .df_pd_hiz(df_pd_hiz), .df_stop_hiz(df_stop_hiz),
        .se_lvl(se_lvl), .se_oe(se_oe), .df_t(df_t), .df_c(df_c),
        .df_t_oe(df_t_oe), .df_c_oe(df_c_oe));

    // Source clock generator, updated on falling clk edges.
    initial begin
        se_clk = 1'b0; df_clk = 1'b0; se_c = 0; df_c_cnt = 0;
        forever begin
            @(negedge clk);
            se_c++;
            if (se_c == H_SE) begin se_clk = ~se_clk; se_c = 0; end
            df_c_cnt++;
            if (df_c_cnt == H_DF) begin df_clk = ~df_clk; df_c_cnt = 0; end
        end
    end

    // Runt monitor on output 0 of each kind (R4).
    initial begin
        forever begin
            @(posedge clk); #2;
            if (se_lvl[0]) run_se++;
            else begin
                if (prev_se && mon_on && run_se < H_SE) runts++;
                if (prev_se) pulses++;
                run_se = 0;
            end
            if (!df_t[0]) run_df++;
            else begin
                if (!prev_df && mon_on && run_df < H_DF) runts++;
                run_df = 0;
            end
            prev_se = se_lvl[0];
            prev_df = df_t[0];
        end
    end

    initial begin
        #1500000;
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic drive_pt();
        @(negedge clk); #1;
    endtask

    task automatic observe(input int n);
        se_hi = '0; se_lo = '0; dt_hi = '0; dt_lo = '0;
        repeat (n) begin
            @(posedge clk); #2;
            se_hi |= se_lvl; se_lo |= ~se_lvl;
            dt_hi |= df_t;   dt_lo |= ~df_t;
        end
    endtask

    task automatic wait_df_fall();
        do begin @(negedge clk); #1; end while (!(df_clk == 1'b0 && df_c_cnt == 0));
    endtask

    task automatic t_reset();
        pd_req = 0; sw_run = 1; se_en = '1; se_stoppable = '0;
        df_en = '1; df_stoppable = '0; df_pd_hiz = 2'b10; df_stop_hiz = 0;
        rst = 1;
        cyc(5);
        check(se_lvl == 3'b000 && se_oe == 3'b111, "R1 se", {2'b0, se_oe, se_lvl}, 8'h38);
        check(df_t == 2'b00 && df_c == 2'b11 && df_t_oe == 2'b11 && df_c_oe == 2'b11,
              "R1 df", {df_t, df_c, df_t_oe, df_c_oe}, 8'h3F);
        drive_pt(); rst = 0;
        cyc(20);
        mon_on = 1;
    endtask

    task automatic t_free_run();
        observe(30);
        check(se_hi == 3'b111 && se_lo == 3'b111, "R2 se toggles", {2'b0, se_hi, se_lo}, 8'h3F);
        check(dt_hi == 2'b11 && dt_lo == 2'b11, "R2 df toggles", {4'b0, dt_hi, dt_lo}, 8'h0F);
        cyc(1);
        check(df_c == ~df_t && df_t_oe == 2'b11 && df_c_oe == 2'b11, "R2 df complement",
              {df_t, df_c, df_t_oe, df_c_oe}, {df_t, ~df_t, 4'hF});
    endtask

    task automatic t_sw_stop();
        drive_pt(); se_stoppable = 3'b001; df_stoppable = 2'b01; df_stop_hiz = 0; sw_run = 0;
        cyc(30);
        observe(30);
        check(se_hi[0] == 1'b0 && se_oe[0], "R3 stoppable se parked low driven",
              {6'b0, se_hi[0], se_oe[0]}, 8'h01);
        check(se_hi[2:1] == 2'b11 && se_lo[2:1] == 2'b11, "R3 free se runs",
              {4'b0, se_hi[2:1], se_lo[2:1]}, 8'h0F);
        check(df_t[0] && df_t_oe[0] && !df_c_oe[0] && dt_lo[0] == 1'b0, "R5 df driven park",
              {5'b0, df_t[0], df_t_oe[0], df_c_oe[0]}, 8'h06);
        check(dt_hi[1] && dt_lo[1], "R5 non-stoppable df runs", {6'b0, dt_hi[1], dt_lo[1]}, 8'h03);
        drive_pt(); df_stop_hiz = 1;
        cyc(2);
        check(!df_t_oe[0] && !df_c_oe[0], "R5 df float park", {6'b0, df_t_oe[0], df_c_oe[0]}, 8'h00);
    endtask

    task automatic t_resume();
        drive_pt(); sw_run = 1; df_stop_hiz = 0;
        cyc(20);
        observe(30);
        check(se_hi[0] && se_lo[0], "R6 se resumes", {6'b0, se_hi[0], se_lo[0]}, 8'h03);
        check(dt_hi[0] && dt_lo[0] && df_t_oe[0] && df_c_oe[0], "R6 df resumes",
              {4'b0, dt_hi[0], dt_lo[0], df_t_oe[0], df_c_oe[0]}, 8'h0F);
    endtask

    task automatic t_pd_single_edge();
        wait_df_fall();
        pd_req = 1;
        repeat (4) @(negedge clk);
        #1 pd_req = 0;
        observe(40);
        check(se_hi == 3'b111 && dt_hi == 2'b11 && dt_lo == 2'b11, "R7 one edge ignored",
              {1'b0, se_hi, 2'b0, dt_lo}, {1'b0, 3'b111, 2'b0, 2'b11});
    endtask

    task automatic t_pd_down();
        wait_df_fall();
        pd_req = 1;
        cyc(40);
        observe(20);
        check(se_hi == 3'b000 && se_oe == 3'b111, "R8 se parked low driven",
              {2'b0, se_hi, se_oe}, 8'h07);
        check(df_t[0] && df_t_oe[0] && !df_c_oe[0] && dt_lo[0] == 1'b0, "R8 df0 driven park",
              {5'b0, df_t[0], df_t_oe[0], df_c_oe[0]}, 8'h06);
        check(!df_t_oe[1] && !df_c_oe[1], "R8 df1 floats", {6'b0, df_t_oe[1], df_c_oe[1]}, 8'h00);
    endtask

    task automatic t_wake();
        drive_pt(); pd_req = 0;
        cyc(2);
        check(df_t[1] && df_t_oe[1] && !df_c_oe[1], "R9 wake drives high",
              {5'b0, df_t[1], df_t_oe[1], df_c_oe[1]}, 8'h06);
        cyc(WAKE - 5);
        check(df_t_oe[1] && df_t[1] && se_lvl == 3'b000, "R9 still parked in window",
              {3'b0, df_t[1], df_t_oe[1], se_lvl}, 8'h18);
        cyc(20);
        observe(30);
        check(dt_hi == 2'b11 && dt_lo == 2'b11 && se_hi == 3'b111, "R9 resume after window",
              {1'b0, se_hi, dt_hi, dt_lo}, 8'h7F);
    endtask

    task automatic t_enable_off();
        drive_pt(); se_en = 3'b101; df_en = 2'b01;
        observe(30);
        check(!se_oe[1] && !se_hi[1], "R10 se disabled running", {6'b0, se_oe[1], se_hi[1]}, 8'h00);
        check(!df_t_oe[1] && !df_c_oe[1] && !dt_hi[1], "R10 df disabled running",
              {5'b0, df_t_oe[1], df_c_oe[1], dt_hi[1]}, 8'h00);
        drive_pt(); sw_run = 0; se_stoppable = '1; df_stoppable = '1; pd_req = 1;
        observe(40);
        check(!se_oe[1] && !se_hi[1] && !df_t_oe[1] && !df_c_oe[1] && !dt_hi[1] && !df_c[1],
              "R10 disabled under stop and pd",
              {3'b0, se_oe[1], se_hi[1], df_t_oe[1], df_c_oe[1], dt_hi[1]}, 8'h00);
        drive_pt(); pd_req = 0; sw_run = 1; se_en = '1; df_en = '1;
        se_stoppable = '0; df_stoppable = '0;
        mon_on = 0;
        cyc(WAKE + 20);
    endtask

    initial begin
        t_reset();
        t_free_run();
        t_sw_stop();
        t_resume();
        t_pd_single_edge();
        t_pd_down();
        t_wake();
        check(runts == 0 && pulses > 10, "R4 no runt phases", 8'(runts), 8'h00);
        t_enable_off();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule